// File: doc/BRIEF.md
# I2C Configuration Register Bank with Soft-Reset Recall

This block is an I2C slave that gives a host access to a small set of configuration registers. Three working registers, at pointer values 00h, 01h and 02h, drive the device's settings through a flat output bus. A nonvolatile shadow copy holds their power-up values. It is modelled as a register array that is loaded from a parameter at hard reset and never written over the bus. Working registers are loaded from the shadow at hard reset.

A control register at AAh carries a soft-reset bit in its most significant position. When the host writes a 1 there, the three working registers are reloaded from the shadow copy without a power cycle, and the bit clears itself in the same clock. A write transfer sends the device address, then a pointer byte, then data bytes. A read transfer sends the device address with the read flag and returns data from the current pointer. The pointer advances after every data byte. A repeated START can set the pointer before a read. Both bus lines pass through a two-flop synchroniser into the system clock domain before any edge is detected.

Top module: `cfg_i2c_bank`

## Requirements
- R1: SDA falling while SCL is high is a START. It begins reception of an address byte from any state. A repeated START in the middle of a byte abandons that byte without writing it and keeps the pointer value.
- R2: SDA rising while SCL is high is a STOP. It returns the slave to idle with SDA released. In idle, clock pulses without a START get no response.
- R3: The slave answers only the 7-bit address 28h. Address bits are sent MSB first, and the eighth bit is the direction, with 0 meaning write. The slave ACKs by holding SDA low for the ninth clock. For any other address SDA stays released until the next START.
- R4: In a write transfer the first data byte loads the pointer. Each further byte is written at the pointer, and then the pointer advances by one, wrapping from FFh to 00h. Every written byte is ACKed.
- R5: In a read transfer the slave shifts out the register at the pointer, MSB first, and changes SDA only while SCL is low. The pointer advances after each byte. A master ACK fetches the next byte. A master NACK releases SDA until the next START.
- R6: Pointers 00h, 01h and 02h are read/write working registers, and register n appears on `cfg_o[8n+7:8n]`. Every pointer other than these and AAh reads 00h, and writes to it change nothing.
- R7: A byte written to AAh with bit 7 set reloads all three working registers from the shadow copy one clock after the byte is accepted. A byte with bit 7 clear causes no reload.
- R8: The soft-reset bit clears itself in the clock that performs the reload, so AAh reads back as 00h after the transfer.
- R9: Bits 6:0 of AAh always read 0 and ignore writes.
- R10: After a hard reset the working registers hold the shadow values 3Ch, 5Ah and 81h (pointers 00h, 01h and 02h), the soft-reset bit is 0, and SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |
| cfg_o | output | 24 | Working registers, register n at bits 8n+7:8n |

## Verification
Two actions share a clock. The soft-reset reload of the three working registers and the self-clear of the AAh control bit both happen in the cycle after the AAh byte is accepted, and the pointer advances in the cycle the byte is accepted. The bench first writes values into the working registers that differ from the shadow. It then writes 80h to AAh, checks that the configuration outputs have returned to the shadow values, and reads AAh back through a repeated START, expecting 00h. If the reload lost the race, the outputs would keep the written values. If the self-clear lost, AAh would read 80h.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } bus_state_e;

endpackage

// File: rtl/cfg_i2c_sync.sv
module cfg_i2c_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.scl_pipe = {s_q.scl_pipe[STAGES-2:0], scl_i};
        s_d.sda_pipe = {s_q.sda_pipe[STAGES-2:0], sda_i};
        s_d.scl_prev = s_q.scl_pipe[STAGES-1];
        s_d.sda_prev = s_q.sda_pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{scl_pipe: '1, sda_pipe: '1, scl_prev: 1'b1, sda_prev: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign scl_s     = s_q.scl_pipe[STAGES-1];
    assign sda_s     = s_q.sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~s_q.scl_prev;
    assign scl_fall  = ~scl_s & s_q.scl_prev;
    assign start_det = scl_s & s_q.scl_prev & s_q.sda_prev & ~sda_s;
    assign stop_det  = scl_s & s_q.scl_prev & ~s_q.sda_prev & sda_s;

endmodule

// File: rtl/cfg_i2c_engine.sv
module cfg_i2c_engine
    import cfg_i2c_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h28,
    parameter int         ADDR_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              sda_oe
);

    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    typedef struct packed {
        bus_state_e        state;
        logic [CNT_W-1:0]  bit_cnt;
        logic [DATA_W-1:0] shift;
        logic              full;
        logic              is_addr;
        logic              ptr_set;
        logic              rd_mode;
        logic              nack;
        logic [ADDR_W-1:0] ptr;
        logic              sda_oe;
    } eng_t;

    eng_t e_d, e_q;

    always_comb begin
        e_d   = e_q;
        wr_en = 1'b0;
        if (start_det) begin
            e_d.state   = ST_RX;
            e_d.bit_cnt = '0;
            e_d.full    = 1'b0;
            e_d.is_addr = 1'b1;
            e_d.ptr_set = 1'b0;
            e_d.rd_mode = 1'b0;
            e_d.sda_oe  = 1'b0;
        end else if (stop_det) begin
            e_d.state  = ST_IDLE;
            e_d.full   = 1'b0;
            e_d.sda_oe = 1'b0;
        end else begin
            unique case (e_q.state)
                ST_RX: begin
                    if (scl_rise) begin
                        e_d.shift   = {e_q.shift[DATA_W-2:0], sda_s};
                        e_d.bit_cnt = e_q.bit_cnt + 1'b1;
                        if (e_q.bit_cnt == LAST_BIT) begin
                            e_d.full = 1'b1;
                        end
                    end else if (scl_fall && e_q.full) begin
                        e_d.full = 1'b0;
                        if (e_q.is_addr) begin
                            e_d.is_addr = 1'b0;
                            if (e_q.shift[DATA_W-1:1] == SLAVE_ADDR) begin
                                e_d.rd_mode = e_q.shift[0];
                                e_d.state   = ST_RX_ACK;
                                e_d.sda_oe  = 1'b1;
                            end else begin
                                e_d.state = ST_IDLE;
                            end
                        end else if (!e_q.ptr_set) begin
                            e_d.ptr     = ADDR_W'(e_q.shift);
                            e_d.ptr_set = 1'b1;
                            e_d.state   = ST_RX_ACK;
                            e_d.sda_oe  = 1'b1;
                        end else begin
                            wr_en      = 1'b1;
                            e_d.ptr    = e_q.ptr + 1'b1;
                            e_d.state  = ST_RX_ACK;
                            e_d.sda_oe = 1'b1;
                        end
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        e_d.bit_cnt = '0;
                        if (e_q.rd_mode) begin
                            e_d.state  = ST_TX;
                            e_d.shift  = rd_data;
                            e_d.sda_oe = ~rd_data[DATA_W-1];
                        end else begin
                            e_d.state  = ST_RX;
                            e_d.sda_oe = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (e_q.bit_cnt == LAST_BIT) begin
                            e_d.state   = ST_TX_ACK;
                            e_d.sda_oe  = 1'b0;
                            e_d.bit_cnt = '0;
                            e_d.ptr     = e_q.ptr + 1'b1;
                        end else begin
                            e_d.bit_cnt = e_q.bit_cnt + 1'b1;
                            e_d.shift   = {e_q.shift[DATA_W-2:0], 1'b0};
                            e_d.sda_oe  = ~e_q.shift[DATA_W-2];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        e_d.nack = sda_s;
                    end else if (scl_fall) begin
                        if (e_q.nack) begin
                            e_d.state = ST_IDLE;
                        end else begin
                            e_d.state  = ST_TX;
                            e_d.shift  = rd_data;
                            e_d.sda_oe = ~rd_data[DATA_W-1];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '{state: ST_IDLE, bit_cnt: '0, shift: '0, full: 1'b0,
                     is_addr: 1'b0, ptr_set: 1'b0, rd_mode: 1'b0, nack: 1'b0,
                     ptr: '0, sda_oe: 1'b0};
        end else begin
            e_q <= e_d;
        end
    end

    assign wr_addr = e_q.ptr;
    assign wr_data = e_q.shift;
    assign rd_addr = e_q.ptr;
    assign sda_oe  = e_q.sda_oe;

    a_r1_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (e_q.state == ST_RX) && (e_q.bit_cnt == '0) && !e_q.sda_oe);

    a_r2_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (e_q.state == ST_IDLE) && !sda_oe);

    a_r3_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.state == ST_IDLE) |-> !sda_oe);

    a_r5_drive_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> e_q.ptr == $past(e_q.ptr) + 1'b1);

endmodule

// File: rtl/cfg_i2c_regs.sv
module cfg_i2c_regs
    import cfg_i2c_pkg::*;
#(
    parameter int                         NUM_REGS  = 3,
    parameter int                         ADDR_W    = 8,
    parameter logic [ADDR_W-1:0]          SRST_ADDR = 8'hAA,
    parameter logic [NUM_REGS*DATA_W-1:0] NV_INIT   = 24'h815A3C
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [DATA_W-1:0]            rd_data,
    output logic [NUM_REGS*DATA_W-1:0]   regs_o
);

    typedef logic [NUM_REGS-1:0][DATA_W-1:0] bank_t;

    typedef struct packed {
        bank_t regs;
        bank_t nv;
        logic  reload;
    } rf_t;

    rf_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (r_q.reload) begin
            r_d.regs   = r_q.nv;
            r_d.reload = 1'b0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (wr_addr == ADDR_W'(i)) begin
                    r_d.regs[i] = wr_data;
                end
            end
            if (wr_addr == SRST_ADDR && wr_data[DATA_W-1]) begin
                r_d.reload = 1'b1;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == ADDR_W'(i)) begin
                rd_data = r_q.regs[i];
            end
        end
        if (rd_addr == SRST_ADDR) begin
            rd_data = {r_q.reload, {(DATA_W-1){1'b0}}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{regs: NV_INIT, nv: NV_INIT, reload: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign regs_o = r_q.regs;

    a_r7_reload_from_shadow: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.reload |=> r_q.regs == $past(r_q.nv));

    a_r8_bit_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.reload |=> !r_q.reload);

    a_r6_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !r_q.reload && wr_addr >= ADDR_W'(NUM_REGS) && wr_addr != SRST_ADDR)
        |=> $stable(r_q.regs) && !r_q.reload);

    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == SRST_ADDR) |-> rd_data[DATA_W-2:0] == '0);

endmodule

// File: rtl/cfg_i2c_bank.sv
module cfg_i2c_bank
    import cfg_i2c_pkg::*;
#(
    parameter logic [6:0]                 SLAVE_ADDR  = 7'h28,
    parameter int                         NUM_REGS    = 3,
    parameter int                         ADDR_W      = 8,
    parameter logic [ADDR_W-1:0]          SRST_ADDR   = 8'hAA,
    parameter logic [NUM_REGS*DATA_W-1:0] NV_INIT     = 24'h815A3C,
    parameter int                         SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_oe_o,
    output logic [NUM_REGS*DATA_W-1:0] cfg_o
);

    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_data;

    cfg_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    cfg_i2c_engine #(.SLAVE_ADDR(SLAVE_ADDR), .ADDR_W(ADDR_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .sda_oe    (sda_oe_o)
    );

    cfg_i2c_regs #(
        .NUM_REGS  (NUM_REGS),
        .ADDR_W    (ADDR_W),
        .SRST_ADDR (SRST_ADDR),
        .NV_INIT   (NV_INIT)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .regs_o  (cfg_o)
    );

endmodule

// File: tb/cfg_i2c_bank_tb.sv
module cfg_i2c_bank_tb;

    localparam int          CLK_PERIOD = 10;
    localparam int          HALF       = 20;
    localparam logic [6:0]  DEV        = 7'h28;
    localparam logic [23:0] SHADOW     = 24'h815A3C;

    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic [23:0] cfg;
    wire         sda_bus = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_i2c_bank u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .sda_oe_o (sda_oe),
        .cfg_o    (cfg)
    );

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 1'b0;
    bit oe_seen  = 1'b0;

    typedef struct {
        logic [7:0] val;
        string      req;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] got;
    event       rd_ev;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        wait_clk(HALF/2); sda_m = 1'b1;
        wait_clk(HALF/2); scl_m = 1'b1;
        wait_clk(HALF);   sda_m = 1'b0;
        wait_clk(HALF);   scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wait_clk(HALF/2); sda_m = 1'b0;
        wait_clk(HALF/2); scl_m = 1'b1;
        wait_clk(HALF);   sda_m = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic put_bit(input logic b);
        wait_clk(HALF/2); sda_m = b;
        wait_clk(HALF/2); scl_m = 1'b1;
        wait_clk(HALF);   scl_m = 1'b0;
    endtask

    task automatic get_bit(output logic r);
        wait_clk(HALF/2); sda_m = 1'b1;
        wait_clk(HALF/2); scl_m = 1'b1;
        wait_clk(HALF/2); r = sda_bus;
        wait_clk(HALF/2); scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(r);
        ack = ~r;
    endtask

    task automatic read_expect(input logic [7:0] exp, input string req, input logic mack);
        logic [7:0] v;
        logic       r;
        exp_q.push_back('{val: exp, req: req});
        for (int i = 7; i >= 0; i--) begin
            get_bit(r);
            v[i] = r;
        end
        put_bit(~mack);
        got = v;
        -> rd_ev;
    endtask

    task automatic send_ack(input logic [7:0] b, input string req);
        logic ack;
        send_byte(b, ack);
        chk(ack == 1'b1, req, {31'd0, ack}, 32'd1);
    endtask

    initial begin
        forever begin
            exp_t e;
            @(rd_ev);
            e = exp_q.pop_front();
            chk(got == e.val, e.req, {24'd0, got}, {24'd0, e.val});
        end
    end

    always @(posedge clk) if (sda_oe) oe_seen <= 1'b1;

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

    initial begin
        logic ack;
        wait_clk(10);
        rst_n = 1'b1;
        wait_clk(10);
        // R10: reset state
        chk(cfg == SHADOW, "R10", {8'd0, cfg}, {8'd0, SHADOW});
        chk(sda_oe == 1'b0, "R10", {31'd0, sda_oe}, 32'd0);

        // R4 / R6: burst write from pointer 00h
        bus_start();
        send_ack({DEV, 1'b0}, "R3");
        send_ack(8'h00, "R4");
        send_ack(8'h11, "R4");
        send_ack(8'h22, "R4");
        send_ack(8'h33, "R4");
        bus_stop();
        chk(cfg == 24'h332211, "R6", {8'd0, cfg}, 32'h332211);

        // R1 / R5: set pointer, repeated START, burst read, NACK ends it
        bus_start();
        send_ack({DEV, 1'b0}, "R3");
        send_ack(8'h00, "R4");
        bus_start();
        send_ack({DEV, 1'b1}, "R1");
        read_expect(8'h11, "R5", 1'b1);
        read_expect(8'h22, "R5", 1'b1);
        read_expect(8'h33, "R5", 1'b0);
        wait_clk(6);
        chk(sda_oe == 1'b0, "R5", {31'd0, sda_oe}, 32'd0);
        bus_stop();

        // R3: foreign address is never acknowledged
        oe_seen = 1'b0;
        bus_start();
        send_byte({7'h29, 1'b0}, ack);
        chk(ack == 1'b0, "R3", {31'd0, ack}, 32'd0);
        send_byte(8'h00, ack);
        bus_stop();
        chk(oe_seen == 1'b0, "R3", {31'd0, oe_seen}, 32'd0);

        // R2: after STOP, clock pulses without START get no response
        wait_clk(HALF/2);
        scl_m = 1'b0;
        send_byte({DEV, 1'b0}, ack);
        chk(ack == 1'b0, "R2", {31'd0, ack}, 32'd0);

        // R4: pointer wraps FFh -> 00h; R6: write at FFh ignored
        bus_start();
        send_ack({DEV, 1'b0}, "R3");
        send_ack(8'hFF, "R4");
        send_ack(8'h99, "R4");
        send_ack(8'h44, "R4");
        bus_stop();
        chk(cfg == 24'h332244, "R4", {8'd0, cfg}, 32'h332244);

        // R6: unmapped pointer reads 00h after a write
        bus_start();
        send_ack({DEV, 1'b0}, "R3");
        send_ack(8'h10, "R4");
        send_ack(8'h77, "R6");
        bus_start();
        send_ack({DEV, 1'b0}, "R3");
        send_ack(8'h10, "R4");
        bus_start();
        send_ack({DEV, 1'b1}, "R1");
        read_expect(8'h00, "R6", 1'b0);
        bus_stop();

        // R7 / R9: bit 7 clear -> no reload, reserved bits read 0
        bus_start();
        send_ack({DEV, 1'b0}, "R3");
        send_ack(8'hAA, "R4");
        send_ack(8'h7F, "R9");
        bus_stop();
        chk(cfg == 24'h332244, "R7", {8'd0, cfg}, 32'h332244);
        bus_start();
        send_ack({DEV, 1'b0}, "R3");
        send_ack(8'hAA, "R4");
        bus_start();
        send_ack({DEV, 1'b1}, "R1");
        read_expect(8'h00, "R9", 1'b0);
        bus_stop();

        // R7 / R8: soft reset reloads the shadow and clears itself
        bus_start();
        send_ack({DEV, 1'b0}, "R3");
        send_ack(8'hAA, "R4");
        send_ack(8'h80, "R7");
        bus_stop();
        chk(cfg == SHADOW, "R7", {8'd0, cfg}, {8'd0, SHADOW});
        bus_start();
        send_ack({DEV, 1'b0}, "R3");
        send_ack(8'hAA, "R4");
        bus_start();
        send_ack({DEV, 1'b1}, "R1");
        read_expect(8'h00, "R8", 1'b0);
        bus_stop();

        // R1: repeated START mid-byte abandons it, pointer kept
        bus_start();
        send_ack({DEV, 1'b0}, "R3");
        send_ack(8'h01, "R4");
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_start();
        send_ack({DEV, 1'b1}, "R1");
        read_expect(8'h5A, "R1", 1'b0);
        bus_stop();
        chk(cfg == SHADOW, "R1", {8'd0, cfg}, {8'd0, SHADOW});

        wait_clk(10);
        chk(exp_q.size() == 0, "R5", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule